// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block gathers interrupt events raised by on-chip sources and turns each one into a fixed 128-bit vector. It stores each vector into a circular buffer held in system memory and keeps a byte-granular write pointer into that buffer. A host consumer reads the vectors and moves a read pointer forward. While the two pointers differ, or while an overflow is pending, the block holds an interrupt request to the host.

Software sets up the block through a small register file. The registers hold the ring base address, the ring size code, the enable bits, both pointers and a 40-bit address for pointer writeback. The block has one 32-bit memory write port. Each vector goes out through it as four words in consecutive cycles. When writeback is on, one more word follows, which is the write-pointer word stored to the writeback address. When the ring fills, the block keeps writing over the oldest vectors and sets a sticky flag in bit 0 of the write-pointer word. Software clears that flag through a control bit.

Top module: `irq_vec_ring`

## Requirements
- R1: Each vector is stored as four 32-bit words in four consecutive cycles, at ring address + wptr + 0, 4, 8 and 12. The words are: word0 = {24'b0, source id}, word1 = {4'b0, 28-bit source data}, word2 = {16-bit address-space id, 8-bit VM id, 8-bit ring id}, word3 = 0.
- R2: Register BASE (word address 1) holds the ring address shifted right by 8, so the ring address is BASE*256.
- R3: Each stored vector advances wptr by 16. wptr wraps modulo the ring length in bytes, which is 4 << code. The code sits in CTRL[5:1]. Codes below 2 are treated as 2, and codes above the configured maximum are clamped to that maximum.
- R4: irq is high when the ring is enabled and either rptr differs from wptr or the overflow flag is set. Otherwise irq is low. irq follows the pointers with one cycle of lag.
- R5: With overflow detection enabled (CTRL[16]), a vector whose advanced wptr equals rptr sets the overflow flag, which is bit 0 of the WPTR register (word address 3). The vector is still written.
- R6: The overflow flag stays set until a CTRL write with bit 31 set. If a new overflow and a clear happen in the same cycle, the flag stays set. CTRL bit 31 reads back as 0.
- R7: With CTRL[16] clear, wptr still advances and wraps, but the overflow flag is never set.
- R8: With ring enable (CTRL[0]) clear, no vector is stored. Events are held in order and are stored once the ring is enabled again.
- R9: With writeback enabled (CTRL[8]), after the fourth word of each vector the block writes the updated WPTR word, including the flag, to the address {WB_HI[7:0], WB_LO}. WB_LO is word address 4 and WB_HI is word address 5.
- R10: A write to WPTR while the ring is disabled loads the pointer, masked to the ring. The same write while the ring is enabled is ignored. Writes to RPTR (word address 2) are masked to the ring.
- R11: All registers reset to zero. A read returns the register selected by reg_addr one cycle later. WB_HI reads back only its low 8 bits.
- R12: An input queue holds up to QDEPTH events while stores are in progress. ev_ready is low while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event queue can accept |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Address-space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Interrupt request to host |

## Verification
The write-pointer commit that raises a new overflow and a software write of the clear bit can land on the same clock edge. The bench brings this about by first moving the read pointer so that the next vector must overflow. It then watches the memory port for the third word of that vector and drives the clearing CTRL write in exactly that cycle, so the write and the commit share an edge. Two results judge the outcome: the writeback word that follows must carry the flag, and a later WPTR read must still show bit 0 set.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int SRC_W   = 8;
  localparam int DATA_W  = 28;
  localparam int RING_W  = 8;
  localparam int VM_W    = 8;
  localparam int PASID_W = 16;
  localparam int ADDR_W  = 40;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_BASE  = 3'd1;
  localparam logic [2:0] A_RPTR  = 3'd2;
  localparam logic [2:0] A_WPTR  = 3'd3;
  localparam logic [2:0] A_WB_LO = 3'd4;
  localparam logic [2:0] A_WB_HI = 3'd5;

  localparam int C_EN     = 0;
  localparam int C_WB     = 8;
  localparam int C_OVF_EN = 16;
  localparam int C_CLR    = 31;

  typedef struct packed {
    logic [PASID_W-1:0] pasid;
    logic [VM_W-1:0]    vm;
    logic [RING_W-1:0]  ring;
    logic [DATA_W-1:0]  data;
    logic [SRC_W-1:0]   src;
  } ivr_event_t;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_WB} ivr_state_e;
endpackage

// File: rtl/ivr_evq.sv
module ivr_evq
  import ivr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_valid,
  output logic       push_ready,
  input  ivr_event_t push_data,
  input  logic       pop,
  output logic       out_valid,
  output ivr_event_t out_data
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ivr_event_t    store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != CW'(DEPTH));
  assign out_valid  = (count != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && out_valid;
  assign out_data   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R12: a full queue without a pop stays full (no push gets in)
  p_full_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/ivr_pack.sv
module ivr_pack
  import ivr_pkg::*;
(
  input  ivr_event_t  ev,
  input  logic [1:0]  sel,
  output logic [31:0] word
);
  logic [31:0] words [4];

  always_comb begin
    words[0] = {{(32 - SRC_W){1'b0}}, ev.src};
    words[1] = {{(32 - DATA_W){1'b0}}, ev.data};
    words[2] = {ev.pasid, ev.vm, ev.ring};
    words[3] = '0;
    word     = words[sel];
  end
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int LOG2W_MAX = 14,
  localparam int PTR_W = LOG2W_MAX + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       wptr_word,
  output logic              ring_en,
  output logic              wb_en,
  output logic              ovf_en,
  output logic              ovf_clr,
  output logic              wptr_wr,
  output logic [PTR_W-1:0]  wptr_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  ptr_mask,
  output logic [PTR_W-1:0]  rptr
);
  logic [4:0]       size_code, eff_code;
  logic [31:0]      base_q, wb_lo_q;
  logic [7:0]       wb_hi_q;
  logic [PTR_W-1:0] span_m1;

  always_comb begin
    if (size_code < 5'd2)                 eff_code = 5'd2;
    else if (size_code > 5'(LOG2W_MAX))   eff_code = 5'(LOG2W_MAX);
    else                                  eff_code = size_code;
    span_m1  = (PTR_W'(1) << (eff_code + 5'd2)) - PTR_W'(1);
    ptr_mask = span_m1 & ~PTR_W'(15);
  end

  assign ovf_clr    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_CLR];
  assign wptr_wr    = reg_wr && (reg_addr == A_WPTR);
  assign wptr_wdata = reg_wdata[PTR_W-1:0];
  assign ring_base  = {base_q, 8'h00};
  assign wb_addr    = {wb_hi_q, wb_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en   <= 1'b0;
      wb_en     <= 1'b0;
      ovf_en    <= 1'b0;
      size_code <= '0;
      base_q    <= '0;
      wb_lo_q   <= '0;
      wb_hi_q   <= '0;
      rptr      <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            ring_en   <= reg_wdata[C_EN];
            size_code <= reg_wdata[5:1];
            wb_en     <= reg_wdata[C_WB];
            ovf_en    <= reg_wdata[C_OVF_EN];
          end
          A_BASE:  base_q  <= reg_wdata;
          A_RPTR:  rptr    <= reg_wdata[PTR_W-1:0] & ptr_mask;
          A_WB_LO: wb_lo_q <= reg_wdata;
          A_WB_HI: wb_hi_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      case (reg_addr)
        A_CTRL:  reg_rdata <= {15'b0, ovf_en, 7'b0, wb_en, 2'b0, size_code, ring_en};
        A_BASE:  reg_rdata <= base_q;
        A_RPTR:  reg_rdata <= {{(32 - PTR_W){1'b0}}, rptr};
        A_WPTR:  reg_rdata <= wptr_word;
        A_WB_LO: reg_rdata <= wb_lo_q;
        A_WB_HI: reg_rdata <= {24'b0, wb_hi_q};
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivr_store.sv
module ivr_store
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en,
  input  logic              wb_en,
  input  logic              ovf_en,
  input  logic              ovf_clr,
  input  logic              wptr_wr,
  input  logic [PTR_W-1:0]  wptr_wdata,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [PTR_W-1:0]  ptr_mask,
  input  logic [PTR_W-1:0]  rptr,
  input  logic              q_valid,
  input  ivr_event_t        q_data,
  output logic              q_pop,
  output logic [31:0]       wptr_word,
  output logic              irq,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  ivr_state_e       state;
  logic [1:0]       beat;
  logic [PTR_W-1:0] wptr, next_w, rptr_m;
  logic             ovf, commit, ovf_hit;
  ivr_event_t       cur_ev, pack_ev;
  logic [31:0]      pack_word;

  assign pack_ev = (state == ST_IDLE) ? q_data : cur_ev;

  ivr_pack u_pack (
    .ev   (pack_ev),
    .sel  (beat),
    .word (pack_word)
  );

  assign q_pop     = (state == ST_IDLE) && ring_en && q_valid;
  assign next_w    = (wptr + PTR_W'(16)) & ptr_mask;
  assign rptr_m    = rptr & ptr_mask;
  assign commit    = (state == ST_VEC) && (beat == 2'd3);
  assign ovf_hit   = commit && ovf_en && (next_w == rptr_m);
  assign wptr_word = {{(32 - PTR_W){1'b0}}, wptr[PTR_W-1:1], ovf};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beat      <= '0;
      wptr      <= '0;
      ovf       <= 1'b0;
      cur_ev    <= '0;
      irq       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      irq    <= ring_en && ((wptr != rptr_m) || ovf);
      case (state)
        ST_IDLE: begin
          if (q_pop) begin
            cur_ev    <= q_data;
            mem_we    <= 1'b1;
            mem_addr  <= ring_base + ADDR_W'(wptr);
            mem_wdata <= pack_word;
            beat      <= 2'd1;
            state     <= ST_VEC;
          end else if (wptr_wr && !ring_en) begin
            wptr <= wptr_wdata & ptr_mask;
          end
        end
        ST_VEC: begin
          mem_we    <= 1'b1;
          mem_addr  <= ring_base + ADDR_W'(wptr) + ADDR_W'({beat, 2'b00});
          mem_wdata <= pack_word;
          if (beat == 2'd3) begin
            wptr  <= next_w;
            beat  <= 2'd0;
            state <= wb_en ? ST_WB : ST_IDLE;
          end else begin
            beat <= beat + 2'd1;
          end
        end
        ST_WB: begin
          mem_we    <= 1'b1;
          mem_addr  <= wb_addr;
          mem_wdata <= wptr_word;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (ovf_hit)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R8: an idle store engine with the ring disabled issues no memory write
  p_idle_off_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ring_en) |=> !mem_we);
  // R6: the flag holds unless software clears it
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
  // R1: every cycle spent inside a vector burst carries a memory write
  p_vec_burst_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC) |-> mem_we);
  // R9: the writeback beat targets the programmed writeback address
  p_wb_target_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |=> (mem_we && mem_addr == $past(wb_addr)));
endmodule

// File: rtl/irq_vec_ring.sv
module irq_vec_ring
  import ivr_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int LOG2W_MAX = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src,
  input  logic [27:0] ev_data,
  input  logic [7:0]  ev_ring,
  input  logic [7:0]  ev_vm,
  input  logic [15:0] ev_pasid,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_we,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        irq
);
  localparam int PTR_W = LOG2W_MAX + 2;

  ivr_event_t        in_ev, q_data;
  logic              q_valid, q_pop;
  logic              ring_en, wb_en, ovf_en, ovf_clr, wptr_wr;
  logic [PTR_W-1:0]  wptr_wdata, ptr_mask, rptr;
  logic [ADDR_W-1:0] ring_base, wb_addr;
  logic [31:0]       wptr_word;

  assign in_ev = '{pasid: ev_pasid, vm: ev_vm, ring: ev_ring, data: ev_data, src: ev_src};

  ivr_evq #(.DEPTH(QDEPTH)) u_evq (
    .clk        (clk),
    .rst        (rst),
    .push_valid (ev_valid),
    .push_ready (ev_ready),
    .push_data  (in_ev),
    .pop        (q_pop),
    .out_valid  (q_valid),
    .out_data   (q_data)
  );

  ivr_regs #(.LOG2W_MAX(LOG2W_MAX)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wptr_word  (wptr_word),
    .ring_en    (ring_en),
    .wb_en      (wb_en),
    .ovf_en     (ovf_en),
    .ovf_clr    (ovf_clr),
    .wptr_wr    (wptr_wr),
    .wptr_wdata (wptr_wdata),
    .ring_base  (ring_base),
    .wb_addr    (wb_addr),
    .ptr_mask   (ptr_mask),
    .rptr       (rptr)
  );

  ivr_store #(.PTR_W(PTR_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .ring_en    (ring_en),
    .wb_en      (wb_en),
    .ovf_en     (ovf_en),
    .ovf_clr    (ovf_clr),
    .wptr_wr    (wptr_wr),
    .wptr_wdata (wptr_wdata),
    .ring_base  (ring_base),
    .wb_addr    (wb_addr),
    .ptr_mask   (ptr_mask),
    .rptr       (rptr),
    .q_valid    (q_valid),
    .q_data     (q_data),
    .q_pop      (q_pop),
    .wptr_word  (wptr_word),
    .irq        (irq),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  // R4: irq may only be raised while the ring is enabled
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ring_en));
endmodule

// File: tb/irq_vec_ring_tb.sv
`timescale 1ns/1ps
module irq_vec_ring_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src = '0;
  logic [27:0] ev_data = '0;
  logic [7:0]  ev_ring = '0;
  logic [7:0]  ev_vm = '0;
  logic [15:0] ev_pasid = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        irq;

  always #2.5 clk = ~clk;

  irq_vec_ring u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm),
    .ev_pasid(ev_pasid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  localparam logic [39:0] RBASE = 40'h00_0012_3400;
  localparam logic [39:0] WBA   = 40'h12_0000_1000;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [71:0] exp_q[$];
  string       tag_q[$];

  // bench model of the ring state
  logic [15:0] m_w = 0, m_r = 0;
  logic [15:0] m_mask = 16'h0030;
  bit          m_ovf = 0, m_ovfen = 1, m_wb = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8", "unexpected store", {mem_addr, mem_wdata}, 72'h0);
      end else begin
        logic [71:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({mem_addr, mem_wdata} == e, t, "store", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, req, "register read", {40'h0, v}, {40'h0, exp});
  endtask

  // driver: queue expected words, then offer the event
  task automatic push_ev(input logic [7:0] s, input logic [27:0] d, input logic [7:0] rg,
                         input logic [7:0] vm, input logic [15:0] pa, input string req);
    logic [15:0] nw;
    exp_q.push_back({RBASE + 40'(m_w),      {24'h0, s}});  tag_q.push_back(req);
    exp_q.push_back({RBASE + 40'(m_w) + 4,  {4'h0, d}});   tag_q.push_back(req);
    exp_q.push_back({RBASE + 40'(m_w) + 8,  {pa, vm, rg}}); tag_q.push_back(req);
    exp_q.push_back({RBASE + 40'(m_w) + 12, 32'h0});       tag_q.push_back(req);
    nw = (m_w + 16'd16) & m_mask;
    if (m_ovfen && nw == m_r) m_ovf = 1;
    m_w = nw;
    if (m_wb) begin
      exp_q.push_back({WBA, {16'h0, m_w[15:1], m_ovf}});
      tag_q.push_back("R9");
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_data = d; ev_ring = rg; ev_vm = vm; ev_pasid = pa;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, "R1", "drain", 72'(exp_q.size()), 72'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 72'h0, 72'h1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(irq == 1'b0, "R11", "irq after reset", 72'(irq), 72'h0);
    chk(ev_ready == 1'b1, "R12", "ready after reset", 72'(ev_ready), 72'h1);
    rd_chk(3'd0, 32'h0, "R11");
    rd_chk(3'd3, 32'h0, "R11");

    wr(3'd1, 32'h0000_1234);
    wr(3'd4, 32'h0000_1000);
    wr(3'd5, 32'h0000_AB12);
    rd_chk(3'd1, 32'h0000_1234, "R2");
    rd_chk(3'd5, 32'h0000_0012, "R11");
    wr(3'd0, 32'h0001_0009);          // enable, code 4 (64-byte ring), overflow detect
    rd_chk(3'd0, 32'h0001_0009, "R11");

    // R1 / R12: two events, second arrives while first is being stored
    push_ev(8'h5A, 28'hABC_DEF1, 8'h11, 8'h22, 16'h3344, "R1");
    push_ev(8'hC3, 28'h123_4567, 8'hF0, 8'h0F, 16'hBEEF, "R12");
    drain();
    rd_chk(3'd3, 32'h20, "R3");
    chk(irq == 1'b1, "R4", "irq with unread entries", 72'(irq), 72'h1);
    wr(3'd2, 32'h20); m_r = 16'h20;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4", "irq when empty", 72'(irq), 72'h0);

    // R3 wrap and R5 overflow on the fourth vector
    for (int i = 0; i < 4; i++)
      push_ev(8'(i + 1), 28'(i * 3 + 7), 8'(i), 8'(2 * i), 16'(i * 257), "R3");
    drain();
    rd_chk(3'd3, 32'h21, "R5");
    chk(irq == 1'b1, "R4", "irq on overflow with equal pointers", 72'(irq), 72'h1);
    push_ev(8'h77, 28'h0FF_FFFF, 8'h01, 8'h02, 16'h0003, "R5");
    drain();
    rd_chk(3'd3, 32'h31, "R6");
    wr(3'd0, 32'h8001_0009); m_ovf = 0;
    rd_chk(3'd3, 32'h30, "R6");
    rd_chk(3'd0, 32'h0001_0009, "R6");

    // R6 collision: overflow commit and clear on the same edge; R9 writeback
    wr(3'd0, 32'h0001_0109); m_wb = 1;
    wr(3'd2, 32'h0); m_r = 16'h0;
    fork
      push_ev(8'h99, 28'h555_5555, 8'hAA, 8'hBB, 16'hCCDD, "R6");
      begin
        do @(negedge clk); while (!(mem_we && mem_addr == RBASE + 40'h38));
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h8001_0109;
        @(negedge clk);
        reg_wr = 1'b0;
      end
    join
    drain();
    rd_chk(3'd3, 32'h1, "R6");
    wr(3'd0, 32'h8001_0109); m_ovf = 0;
    rd_chk(3'd3, 32'h0, "R6");

    // R7: detection off, pointers meet, no flag
    wr(3'd0, 32'h0000_0109); m_ovfen = 0;
    wr(3'd2, 32'h10); m_r = 16'h10;
    push_ev(8'h42, 28'h000_0042, 8'h42, 8'h42, 16'h0042, "R7");
    drain();
    rd_chk(3'd3, 32'h10, "R7");
    wr(3'd3, 32'h20);
    rd_chk(3'd3, 32'h10, "R10");

    // R8 / R10: ring disabled, pointer reload, events held
    wr(3'd0, 32'h0000_0108);
    wr(3'd3, 32'h0); m_w = 0;
    wr(3'd2, 32'h0); m_r = 0;
    rd_chk(3'd3, 32'h0, "R10");
    wr(3'd2, 32'h1_2345);
    rd_chk(3'd2, 32'h0000_0000 | (32'h1_2345 & 32'h30), "R10");
    wr(3'd2, 32'h0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4", "irq while disabled", 72'(irq), 72'h0);
    for (int i = 0; i < 4; i++)
      push_ev(8'(8'hE0 + i), 28'(32'h0AB_0000 + i), 8'(i), 8'(i), 16'(16'h1000 + i), "R8");
    chk(ev_ready == 1'b0, "R12", "ready low with full queue", 72'(ev_ready), 72'h0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 20, "R8", "no stores while disabled", 72'(exp_q.size()), 72'd20);
    wr(3'd0, 32'h0000_0109);
    drain();
    rd_chk(3'd3, 32'h0, "R8");
    chk(ev_ready == 1'b1, "R12", "ready after drain", 72'(ev_ready), 72'h1);

    finish_run();
  end
endmodule